// File: doc/BRIEF.md
# Thirteen-Cell Boundary Register with Grouped Output Enables

This block is the boundary register of a small device that has one clock input, six data inputs and six three-state data outputs. It forms a single 13-cell serial chain between a serial input and a serial output. Each cell has a capture/shift flop and an update latch. A separate TAP controller supplies the capture, shift and update strobes and a two-bit test mode. The TAP state machine and instruction decoding are not part of this block.

The cells sit between the device pins and the core. In the external-test mode the update latches drive the output pads, so board interconnect can be exercised. In the internal-test mode the latches drive the core inputs and the core clock, and the core responses can be captured. In every other mode pins and core connect straight through, and a capture takes a snapshot without disturbing operation. Two of the output cells also serve as enable controls, each for a group of three outputs. A control value of 1 puts its group in high impedance.

Top module: `bscan_reg13`

## Requirements
- R1: While `rst_n` is low, and after it returns high, every shift flop holds 0. Every update latch holds 0, except the two control latches (cells 0 and 5), which hold 1. In external test after reset, `pad_oe` is 0, `pad_q` is 6'b100001 and `sout` is 0.
- R2: Cell numbering is 12 down to 0. While `shift_en` is high and `cap_en` is low, each `clk` rising edge moves `sin` into cell 12 and each cell into the next lower one. `sout` always shows cell 0, so the first bit shifted in reaches cell 0 after 13 shifts.
- R3: A rising edge with `cap_en` high loads all 13 cells at once. Cell 12 takes `pin_clk` and cell 12-n takes `pin_din[n-1]` (n = 1..6). Output cell 6-n takes the driven pad value `pad_q[n-1]` when `mode` is 2'b01, and `core_q[n-1]` otherwise.
- R4: The update latches copy the whole shift stage on a rising edge with `upd_en` high, and at no other time. Pad and core outputs therefore stay steady while shifting.
- R5: With `mode` = 2'b01 (external test), `pad_q[n-1]` equals the update latch of cell 6-n.
- R6: With `mode` = 2'b01 or 2'b10, outputs 1-3 (`pad_oe[2:0]`) are all 0 when the cell 0 latch is 1 and all 1 when it is 0. Outputs 4-6 (`pad_oe[5:3]`) follow the cell 5 latch in the same way.
- R7: With `mode` = 2'b00 (sample/preload), the pads and core are connected straight through: `pad_q`=`core_q`, `core_din`=`pin_din`, `core_clk`=`pin_clk`, `pad_oe[2:0]`={3{`core_oe[0]`}}, `pad_oe[5:3]`={3{`core_oe[1]`}}. This holds whatever the latches contain.
- R8: With `mode` = 2'b10 (internal test), `core_din[n-1]` equals the cell 12-n latch and `core_clk` equals the cell 12 latch. The pads are held from the latches as in R5 and R6.
- R9: When `cap_en` and `shift_en` are both high, capture takes priority. When `upd_en` and `shift_en` are both high, the latches receive the shift stage as it was before that edge's shift.
- R10: `mode` = 2'b11 behaves exactly as 2'b00 for both pass-through and capture.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Test clock |
| rst_n | input | 1 | Asynchronous active-low TAP reset |
| mode | input | 2 | 00 sample/preload, 01 external test, 10 internal test, 11 functional |
| cap_en | input | 1 | Parallel capture strobe |
| shift_en | input | 1 | Serial shift strobe |
| upd_en | input | 1 | Update strobe |
| sin | input | 1 | Serial data into cell 12 |
| sout | output | 1 | Serial data from cell 0 |
| pin_clk | input | 1 | Clock pin of the device |
| pin_din | input | 6 | Data input pins 1..6 (bit n-1 = input n) |
| core_clk | output | 1 | Clock delivered to the core |
| core_din | output | 6 | Data delivered to the core |
| core_q | input | 6 | Core output data 1..6 |
| core_oe | input | 2 | Functional enables: bit 0 outputs 1-3, bit 1 outputs 4-6 |
| pad_q | output | 6 | Data to output pads |
| pad_oe | output | 6 | Per-pad drive enable, 1 drives |

## Verification
Two functions can fall on the same edge in this block: capture can coincide with shift, and update can coincide with shift. The bench raises both strobes of each pair in a single cycle. For the capture case, it reads the chain back and expects the pure capture image with no shifted bit in it. For the update case, it switches to external test and expects the pads to show the pattern that sat in the chain before that edge, not the pattern one step further along.

// File: rtl/bscan_reg13.sv
module bscan_reg13 #(
  parameter int NIN    = 6,
  parameter int NOUT   = 6,
  parameter int CTL_LO = 0,
  parameter int CTL_HI = NOUT - 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [1:0]      mode,
  input  logic            cap_en,
  input  logic            shift_en,
  input  logic            upd_en,
  input  logic            sin,
  output logic            sout,
  input  logic            pin_clk,
  input  logic [NIN-1:0]  pin_din,
  output logic            core_clk,
  output logic [NIN-1:0]  core_din,
  input  logic [NOUT-1:0] core_q,
  input  logic [1:0]      core_oe,
  output logic [NOUT-1:0] pad_q,
  output logic [NOUT-1:0] pad_oe
);
  localparam int NCELL    = 1 + NIN + NOUT;
  localparam int CLK_CELL = NCELL - 1;
  localparam int HALF     = NOUT / 2;
  localparam logic [1:0] M_EXT = 2'b01;
  localparam logic [1:0] M_INT = 2'b10;

  logic [NCELL-1:0] sr, upd, cap_vec, upd_init;
  logic ext_m, int_m, test_m;

  assign ext_m  = (mode == M_EXT);
  assign int_m  = (mode == M_INT);
  assign test_m = ext_m | int_m;
  assign sout   = sr[0];

  always_comb begin
    upd_init = '0;
    upd_init[CTL_LO] = 1'b1;
    upd_init[CTL_HI] = 1'b1;
  end

  always_comb begin
    cap_vec = '0;
    cap_vec[CLK_CELL] = pin_clk;
    for (int i = 0; i < NIN; i++) cap_vec[NOUT+NIN-1-i] = pin_din[i];
    for (int i = 0; i < NOUT; i++) cap_vec[NOUT-1-i] = ext_m ? pad_q[i] : core_q[i];
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)        sr <= '0;
    else if (cap_en)   sr <= cap_vec;
    else if (shift_en) sr <= {sin, sr[NCELL-1:1]};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)      upd <= upd_init;
    else if (upd_en) upd <= sr;

  always_comb begin
    for (int i = 0; i < NOUT; i++) begin
      pad_q[i]  = test_m ? upd[NOUT-1-i] : core_q[i];
      if (i < HALF) pad_oe[i] = test_m ? ~upd[CTL_LO] : core_oe[0];
      else          pad_oe[i] = test_m ? ~upd[CTL_HI] : core_oe[1];
    end
    for (int i = 0; i < NIN; i++)
      core_din[i] = int_m ? upd[NOUT+NIN-1-i] : pin_din[i];
    core_clk = int_m ? upd[CLK_CELL] : pin_clk;
  end

  p_shift_in_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (shift_en && !cap_en) |=> (sr[NCELL-1] == $past(sin)) && (sout == $past(sr[1])));

  p_cap_clk_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cap_en |=> sr[CLK_CELL] == $past(pin_clk));

  p_latch_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !upd_en |=> $stable(upd));

  p_grp_hiz_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (test_m && upd[CTL_LO]) |-> (pad_oe[HALF-1:0] == '0));

  p_passthru_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'b00) |-> (pad_q == core_q) && (core_din == pin_din));

  p_upd_vs_shift_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_en && shift_en && !cap_en) |=> upd == $past(sr));
endmodule

// File: tb/sim_bscan_reg13.sv
module sim_bscan_reg13;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [1:0] mode = 2'b01;
  logic cap_en = 0, shift_en = 0, upd_en = 0, sin = 0, pin_clk = 0;
  logic [5:0] pin_din = '0, core_q = '0;
  logic [1:0] core_oe = '0;
  logic sout, core_clk;
  logic [5:0] core_din, pad_q, pad_oe;
  int n_chk = 0, n_bad = 0;
  logic [12:0] got, lat;

  always #5 clk = ~clk;

  bscan_reg13 u0 (.clk(clk), .rst_n(rst_n), .mode(mode), .cap_en(cap_en),
    .shift_en(shift_en), .upd_en(upd_en), .sin(sin), .sout(sout),
    .pin_clk(pin_clk), .pin_din(pin_din), .core_clk(core_clk),
    .core_din(core_din), .core_q(core_q), .core_oe(core_oe),
    .pad_q(pad_q), .pad_oe(pad_oe));

  // {mode, latch pattern, core_q, core_oe, pin_din, pin_clk}
  localparam logic [29:0] VEC [6] = '{
    {2'b01, 13'b1010101011110, 6'h2D, 2'b11, 6'h13, 1'b0},
    {2'b01, 13'b0110011100001, 6'h00, 2'b00, 6'h3F, 1'b1},
    {2'b01, 13'b0000000100000, 6'h3F, 2'b11, 6'h00, 1'b0},
    {2'b10, 13'b1110010011110, 6'h15, 2'b01, 6'h2A, 1'b0},
    {2'b00, 13'b1111111111111, 6'h39, 2'b10, 6'h0C, 1'b1},
    {2'b11, 13'b0000000000000, 6'h27, 2'b01, 6'h31, 1'b0}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic scan(input logic [12:0] pat, output logic [12:0] rd, input bit do_upd);
    for (int i = 0; i < 13; i++) begin
      @(negedge clk); rd[i] = sout; sin = pat[i]; shift_en = 1;
    end
    @(negedge clk); shift_en = 0; upd_en = do_upd;
    @(negedge clk); upd_en = 0;
  endtask

  task automatic capture();
    @(negedge clk); cap_en = 1;
    @(negedge clk); cap_en = 0;
  endtask

  function automatic logic [5:0] e_padq(logic [1:0] m, logic [12:0] l, logic [5:0] cq);
    logic [5:0] r;
    for (int i = 0; i < 6; i++) r[i] = (m == 2'b01 || m == 2'b10) ? l[5-i] : cq[i];
    return r;
  endfunction

  function automatic logic [5:0] e_oe(logic [1:0] m, logic [12:0] l, logic [1:0] co);
    if (m == 2'b01 || m == 2'b10) return {{3{~l[5]}}, {3{~l[0]}}};
    return {{3{co[1]}}, {3{co[0]}}};
  endfunction

  function automatic logic [6:0] e_core(logic [1:0] m, logic [12:0] l, logic [5:0] pd, logic pc);
    logic [6:0] r;
    for (int i = 0; i < 6; i++) r[i] = (m == 2'b10) ? l[11-i] : pd[i];
    r[6] = (m == 2'b10) ? l[12] : pc;
    return r;
  endfunction

  function automatic logic [12:0] e_cap(logic [1:0] m, logic [12:0] l, logic [5:0] cq,
                                        logic [5:0] pd, logic pc);
    logic [12:0] v;
    v[12] = pc;
    for (int i = 0; i < 6; i++) v[11-i] = pd[i];
    for (int i = 0; i < 6; i++) v[5-i] = (m == 2'b01) ? l[5-i] : cq[i];
    return v;
  endfunction

  initial begin
    #2_000_000;
    n_bad++;
    $display("FAIL watchdog: got hang expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    chk("R1 oe in reset", pad_oe, 6'h00);
    rst_n = 1;
    @(negedge clk);
    chk("R1 pad_q", pad_q, 6'b100001);
    chk("R1 pad_oe", pad_oe, 6'h00);
    chk("R1 sout", sout, 0);
    scan(13'h0AAA, got, 0);
    chk("R1 chain zero", got, 13'h0);
    scan(13'h1357, got, 0);
    chk("R2 chain order", got, 13'h0AAA);

    foreach (VEC[k]) begin
      logic [1:0] m; logic [12:0] p; string tg;
      {m, p, core_q, core_oe, pin_din, pin_clk} = VEC[k];
      mode = m;
      tg = (m == 2'b01) ? "R5/R6" : (m == 2'b10) ? "R8/R6" : (m == 2'b00) ? "R7" : "R10";
      scan(p, got, 1);
      chk({tg, " pad_q"}, pad_q, e_padq(m, p, core_q));
      chk({tg, " pad_oe"}, pad_oe, e_oe(m, p, core_oe));
      chk({tg, " core"}, {core_clk, core_din}, e_core(m, p, pin_din, pin_clk));
    end

    // capture in each mode; latches still hold 0 from last vector
    lat = 13'h0;
    core_q = 6'h2B; pin_din = 6'h19; pin_clk = 1;
    mode = 2'b00; capture(); scan(13'h0, got, 0);
    chk("R3 sample capture", got, e_cap(2'b00, lat, core_q, pin_din, pin_clk));
    mode = 2'b11; capture(); scan(13'h0, got, 0);
    chk("R10 capture", got, e_cap(2'b11, lat, core_q, pin_din, pin_clk));
    lat = 13'b0101100101101;
    mode = 2'b01; scan(lat, got, 1);
    capture(); scan(13'h0, got, 0);
    chk("R3 ext capture", got, e_cap(2'b01, lat, core_q, pin_din, pin_clk));
    mode = 2'b10; capture(); scan(13'h0, got, 0);
    chk("R3 int capture", got, e_cap(2'b10, lat, core_q, pin_din, pin_clk));

    // R4: pads steady while shifting without update
    mode = 2'b01;
    for (int i = 0; i < 13; i++) begin
      @(negedge clk);
      chk("R4 pads steady", {pad_oe, pad_q}, {e_oe(2'b01, lat, core_oe), e_padq(2'b01, lat, core_q)});
      sin = ~i[0]; shift_en = 1;
    end
    @(negedge clk); shift_en = 0;
    chk("R4 pads after shift", pad_q, e_padq(2'b01, lat, core_q));

    // R9: capture and shift in the same cycle
    mode = 2'b00; core_q = 6'h0E; pin_din = 6'h33; pin_clk = 0;
    @(negedge clk); cap_en = 1; shift_en = 1; sin = 1;
    @(negedge clk); cap_en = 0; shift_en = 0;
    scan(13'h0, got, 0);
    chk("R9 capture over shift", got, e_cap(2'b00, lat, core_q, pin_din, pin_clk));

    // R9: update and shift in the same cycle
    lat = 13'b1001110100010;
    scan(lat, got, 0);
    @(negedge clk); shift_en = 1; upd_en = 1; sin = 1;
    @(negedge clk); shift_en = 0; upd_en = 0; mode = 2'b01;
    @(negedge clk);
    chk("R9 update pre-shift pad_q", pad_q, e_padq(2'b01, lat, core_q));
    chk("R9 update pre-shift oe", pad_oe, e_oe(2'b01, lat, core_oe));

    // R6: both groups disabled
    lat = 13'b0000000100001;
    scan(lat, got, 1);
    chk("R6 both groups off", pad_oe, 6'h00);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule